// File: doc/BRIEF.md
# Gated Binary Up-Counter with Paired Enables

This block is a binary up-counter. Its width is set by a parameter and defaults to eight bits. It steps by one on each rising clock edge while it is allowed to run, and it holds its value otherwise.

Two synchronous gate inputs decide whether it runs:

- If the two gates agree (both low or both high), the counter runs.
- If they disagree, the counter is frozen.

The gates are sampled on the same edge that would advance the count. A request to freeze therefore stops that very edge from stepping the value. A separate run-override input forces counting whatever the gates say. An asynchronous clear drives the value to zero at once.

The block also provides a bitwise-inverted copy of the count. It suits clock-division and time-measurement work, where a counter has to be paused and resumed without losing its place.

Top module: `gated_upcount`

## Requirements
- R1: While `clr` is high, `value` is 0 and `value_n` is all ones. This takes effect at once, without a clock edge, and whatever the other inputs are.
- R2: With `gate_a` and `gate_b` both low, each rising edge of `clk` adds 1 to `value`.
- R3: When exactly one of `gate_a` and `gate_b` is high at a rising edge and `force_run` is low, that edge leaves `value` unchanged. This holds for either gate, and the edge at which the gates first disagree does not advance the count either.
- R4: With `gate_a` and `gate_b` both high, each rising edge adds 1 to `value`. Counting resumes from the held value.
- R5: When `force_run` is high at a rising edge, that edge adds 1 to `value` even if the gates disagree.
- R6: The count wraps from all ones (0xFF at the default width) to 0 on an advancing edge.
- R7: `value_n` is always the bitwise inverse of `value`.
- R8: After `clr` falls with the gates in agreement, the first rising edge takes `value` from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Asynchronous clear, active high |
| force_run | input | 1 | Run override, sampled on the clock, active high |
| gate_a | input | 1 | First synchronous gate |
| gate_b | input | 1 | Second synchronous gate |
| value | output | W | Current count |
| value_n | output | W | Bitwise inverse of the count |

## Verification
The counter is driven through each gate combination in turn: both low, only `gate_a` high, only `gate_b` high, and both high. This separates the agree-runs rule from an AND or OR reading of the gates, and it shows that a disagreement freezes the count on its first edge and not one edge later.

The override is applied while the gates disagree, which shows it dominates them. A long run up to the top value exposes the wrap, and a clear raised in the middle of a clock phase shows that it acts with no edge at all. The inverted output is compared after every step.

// File: rtl/gated_upcount.sv
module gated_upcount #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         force_run,
  input  logic         gate_a,
  input  logic         gate_b,
  output logic [W-1:0] value,
  output logic [W-1:0] value_n
);

  logic gate_ok;
  logic step;
  logic gate_q;

  assign gate_ok = ~(gate_a ^ gate_b);
  assign step    = gate_ok | force_run;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      gate_q <= 1'b1;
      value  <= '0;
    end else begin
      gate_q <= gate_ok;
      if (step) value <= value + 1'b1;
    end
  end

  assign value_n = ~value;

  // R1
  clr_zero_chk: assert property (@(posedge clk) clr |-> (value == '0));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (clr)
    ((gate_a ^ gate_b) && !force_run) |=> (value == $past(value)));

  // R2 R4 R5
  advance_chk: assert property (@(posedge clk) disable iff (clr)
    ((gate_a == gate_b) || force_run) |=> (value == W'($past(value) + 1'b1)));

  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (clr)
    ((value == {W{1'b1}}) && ((gate_a == gate_b) || force_run)) |=> (value == '0));

  // R3
  moved_only_when_allowed_chk: assert property (@(posedge clk) disable iff (clr)
    (value != $past(value)) |-> (gate_q || $past(force_run)));

endmodule

// File: tb/sim_gated_upcount.sv
module sim_gated_upcount;
  localparam int W = 8;
  localparam time PERIOD = 10;

  logic clk = 0;
  logic clr = 1;
  logic force_run = 0;
  logic gate_a = 0;
  logic gate_b = 0;
  logic [W-1:0] value, value_n;
  logic [W-1:0] exp_v;
  int checks = 0, fails = 0;
  bit done = 0;

  gated_upcount #(.W(W)) u0 (
    .clk(clk), .clr(clr), .force_run(force_run),
    .gate_a(gate_a), .gate_b(gate_b),
    .value(value), .value_n(value_n)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic step(input logic a, input logic b, input logic f, input string req);
    gate_a = a; gate_b = b; force_run = f;
    @(posedge clk);
    @(negedge clk);
    if ((a == b) || f) exp_v = exp_v + 1'b1;
    check(req, value, exp_v);
    check("R7", value_n, ~exp_v);
  endtask

  task automatic t_reset();
    clr = 1; gate_a = 0; gate_b = 0; force_run = 0;
    @(negedge clk); @(negedge clk);
    check("R1", value, '0);
    check("R1", value_n, '1);
    clr = 0; exp_v = '0;
    step(0, 0, 0, "R8");
    check("R8", value, 8'd1);
  endtask

  task automatic t_both_low();
    for (int i = 0; i < 5; i++) step(0, 0, 0, "R2");
  endtask

  task automatic t_one_high();
    step(1, 0, 0, "R3");
    step(1, 0, 0, "R3");
    step(0, 1, 0, "R3");
    step(0, 1, 0, "R3");
  endtask

  task automatic t_both_high();
    for (int i = 0; i < 4; i++) step(1, 1, 0, "R4");
    step(1, 0, 0, "R3");
    step(1, 1, 0, "R4");
  endtask

  task automatic t_override();
    step(1, 0, 1, "R5");
    step(0, 1, 1, "R5");
    step(0, 1, 0, "R3");
  endtask

  task automatic t_wrap();
    while (exp_v != {W{1'b1}}) step(0, 0, 0, "R2");
    check("R6", value, 8'hFF);
    step(1, 1, 0, "R6");
    check("R6", value, 8'h00);
  endtask

  task automatic t_async_clear();
    step(0, 0, 0, "R2");
    step(0, 0, 0, "R2");
    #(PERIOD/4);
    clr = 1;
    #1;
    check("R1", value, '0);
    check("R1", value_n, '1);
    @(negedge clk);
    check("R1", value, '0);
    clr = 0; exp_v = '0;
    step(1, 1, 0, "R8");
    check("R8", value, 8'd1);
  endtask

  initial begin
    exp_v = '0;
    @(negedge clk);
    t_reset();
    t_both_low();
    t_one_high();
    t_both_high();
    t_override();
    t_wrap();
    t_async_clear();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule